// File: doc/BRIEF.md
# Multi-Source Reloadable Down Timer

This block is an 8-bit binary down counter that divides one of four count sources by a programmable ratio. The sources are a PWM signal, a prescaler output and the underflow of a wide fixed-ratio timer, each given as a one-cycle enable strobe, plus an external pin that is synchronised before use. On every enabled source event the count drops by one. When an event arrives at a count of zero, the counter reloads from its reload register in that same cycle. This gives a division by the reload value plus one.

Each underflow produces a one-cycle pulse and sets a sticky interrupt flag, which a write-one-to-clear strobe clears. Each underflow also toggles an output pin. Software uses a narrow write port to set the reload value, the run bit and the source select. While the timer is stopped, a reload write also presets the count.

Top module: `rld_down_timer`

## Requirements
- R1: After reset the count and the reload register are 0x00, the timer is stopped with source code 0, and the underflow pulse, interrupt flag and output pin are all low. Source events while stopped do not change the count.
- R2: With reload value n, one underflow occurs every n+1 enabled source events. A value of 0x00 gives an underflow on every event, and 0xFF gives one every 256 events.
- R3: While running, each enabled event at a nonzero count lowers the count by one. When the timer is not running, or no selected event occurs, the count holds its value.
- R4: An enabled event at a count of zero reloads the count from the reload register at the same clock edge. The underflow pulse is high for the one cycle that follows that edge.
- R5: A control write (select = 1) sets run from data bit 0 and the source from data bits 2:1. The source codes are 0 = PWM strobe, 1 = prescaler strobe, 2 = wide-timer underflow strobe and 3 = external pin. Strobes from unselected sources are ignored.
- R6: The external pin passes through a two-stage synchroniser. Each low-to-high transition counts as exactly one event, however long the pin then stays high.
- R7: The interrupt flag is set by each underflow and stays set until a clear strobe is applied. If an underflow and a clear happen in the same cycle, the flag is set.
- R8: The output pin toggles at each underflow edge and otherwise holds its level.
- R9: A reload write (select = 0) always updates the reload register. It also loads the count when the timer is stopped. While the timer is running, it leaves the count unchanged until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = reload register, 1 = control register |
| reg_wr_data | input | 8 | Write data |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| src_pwm_stb | input | 1 | PWM source enable strobe |
| src_presc_stb | input | 1 | Prescaler source enable strobe |
| src_wide_uf_stb | input | 1 | Wide timer underflow strobe |
| ext_cnt_pin | input | 1 | Asynchronous external count input |
| count_val | output | 8 | Current count |
| uf_pulse | output | 1 | One-cycle underflow pulse |
| irq_flag | output | 1 | Sticky interrupt request |
| cnt_out_pin | output | 1 | Toggling counter output |

## Verification
The hardest case to reach is an underflow that lands in the same cycle as an interrupt clear, because the clear must lose. The stimulus reaches it by presetting the count to zero while the timer is stopped, then starting it. The next selected strobe is then certain to underflow, and the bench raises the clear strobe in exactly that cycle. The full 256-event division and the latency through the pin synchroniser get dedicated runs. In these runs a reference model steps along with every enabled event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SRC_PWM   = 2'd0,
      SRC_PRESC = 2'd1,
      SRC_WIDE  = 2'd2,
      SRC_PIN   = 2'd3
   } src_sel_e;

   localparam int SRC_COUNT    = 4;
   localparam int SRC_SEL_W    = 2;
   localparam logic REG_RELOAD = 1'b0;
   localparam logic REG_CTRL   = 1'b1;
   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_SRC_LSB = 1;
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rld_q,
   output logic             run_q,
   output src_sel_e         src_q,
   output logic             load_stb,
   output logic [CNT_W-1:0] load_val
);
   localparam int CTRL_BITS = CTRL_SRC_LSB + SRC_SEL_W;

   if (CNT_W < CTRL_BITS) begin : g_bad_width
      $error("tmr_cfg_regs: CNT_W too narrow for control fields");
   end

   logic wr_rld, wr_ctl;
   assign wr_rld = wr_en && (wr_sel == REG_RELOAD);
   assign wr_ctl = wr_en && (wr_sel == REG_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q <= '0;
         run_q <= 1'b0;
         src_q <= SRC_PWM;
      end else begin
         if (wr_rld) rld_q <= wr_data;
         if (wr_ctl) begin
            run_q <= wr_data[CTRL_RUN_BIT];
            src_q <= src_sel_e'(wr_data[CTRL_SRC_LSB +: SRC_SEL_W]);
         end
      end
   end

   assign load_stb = wr_rld && !run_q;
   assign load_val = wr_data;

   assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl |=> ($stable(run_q) && $stable(src_q)));
   assert_rld_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rld |=> (rld_q == $past(wr_data)));
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int   SYNC_STAGES = 2,
   parameter logic RISE_EDGE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic edge_stb
);
   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_edge_sync: at least two synchroniser stages required");
   end

   logic [MSB:0] sync_q;
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], pin_in};
         prev_q <= sync_q[MSB];
      end
   end

   if (RISE_EDGE) begin : g_rise
      assign edge_stb = sync_q[MSB] && !prev_q;
   end else begin : g_fall
      assign edge_stb = !sync_q[MSB] && prev_q;
   end

   assert_single_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_stb |=> !edge_stb);
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] rld,
   output logic [CNT_W-1:0] cnt_q,
   output logic             uf
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_down_core: CNT_W must be at least 2");
   end

   logic at_zero;
   assign at_zero = (cnt_q == '0);
   assign uf      = cnt_en && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_stb) begin
         cnt_q <= load_val;
      end else if (cnt_en) begin
         cnt_q <= at_zero ? rld : cnt_q - 1'b1;
      end
   end

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load_stb && cnt_q == '0) |=> (cnt_q == $past(rld)));
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load_stb && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load_stb) |=> $stable(cnt_q));
   assert_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl #(
   parameter logic PIN_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uf_in,
   input  logic irq_clr,
   output logic uf_q,
   output logic irq_q,
   output logic pin_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q  <= 1'b0;
         irq_q <= 1'b0;
         pin_q <= PIN_RESET;
      end else begin
         uf_q <= uf_in;
         if (uf_in)        irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
         if (uf_in)        pin_q <= !pin_q;
      end
   end

   assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      uf_in |=> irq_q);
   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !irq_clr) |=> irq_q);
   assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uf_in |=> (pin_q != $past(pin_q)));
   assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !uf_in |=> $stable(pin_q));
endmodule

// File: rtl/rld_down_timer.sv
module rld_down_timer
   import tmr_pkg::*;
#(
   parameter int   CNT_W       = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_RESET   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic             reg_wr_sel,
   input  logic [CNT_W-1:0] reg_wr_data,
   input  logic             irq_clr,
   input  logic             src_pwm_stb,
   input  logic             src_presc_stb,
   input  logic             src_wide_uf_stb,
   input  logic             ext_cnt_pin,
   output logic [CNT_W-1:0] count_val,
   output logic             uf_pulse,
   output logic             irq_flag,
   output logic             cnt_out_pin
);
   logic [CNT_W-1:0]     rld, load_val;
   logic                 run, load_stb, pin_evt, cnt_en, uf;
   src_sel_e             src;
   logic [SRC_COUNT-1:0] src_vec;

   tmr_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
      .rld_q(rld), .run_q(run), .src_q(src),
      .load_stb(load_stb), .load_val(load_val)
   );

   tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .RISE_EDGE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(ext_cnt_pin), .edge_stb(pin_evt)
   );

   always_comb begin
      src_vec            = '0;
      src_vec[SRC_PWM]   = src_pwm_stb;
      src_vec[SRC_PRESC] = src_presc_stb;
      src_vec[SRC_WIDE]  = src_wide_uf_stb;
      src_vec[SRC_PIN]   = pin_evt;
   end

   assign cnt_en = run && src_vec[src];

   tmr_down_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .cnt_en(cnt_en), .load_stb(load_stb), .load_val(load_val),
      .rld(rld), .cnt_q(count_val), .uf(uf)
   );

   tmr_out_ctrl #(.PIN_RESET(PIN_RESET)) u_out (
      .clk(clk), .rst_n(rst_n),
      .uf_in(uf), .irq_clr(irq_clr),
      .uf_q(uf_pulse), .irq_q(irq_flag), .pin_q(cnt_out_pin)
   );

   assert_en_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count_val) || $past(load_stb));
endmodule

// File: tb/test_rld_down_timer.sv
module test_rld_down_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic       irq_clr = 1'b0;
   logic       src_pwm_stb = 1'b0, src_presc_stb = 1'b0, src_wide_uf_stb = 1'b0;
   logic       ext_cnt_pin = 1'b0;
   logic [7:0] count_val;
   logic       uf_pulse, irq_flag, cnt_out_pin;

   int errors = 0;
   int checks = 0;

   int       m_cnt = 0, m_rld = 0, m_src = 0;
   logic     m_run = 0, m_pin = 0, m_irq = 0, m_uf = 0;

   always #5 clk = ~clk;

   rld_down_timer i_rld_down_timer (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .irq_clr(irq_clr),
      .src_pwm_stb(src_pwm_stb), .src_presc_stb(src_presc_stb),
      .src_wide_uf_stb(src_wide_uf_stb), .ext_cnt_pin(ext_cnt_pin),
      .count_val(count_val), .uf_pulse(uf_pulse),
      .irq_flag(irq_flag), .cnt_out_pin(cnt_out_pin)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      chk({req, " count"}, count_val, m_cnt);
      chk({req, " uf_pulse"}, uf_pulse, m_uf);
      chk({req, " irq"}, irq_flag, m_irq);
      chk({req, " pin"}, cnt_out_pin, m_pin);
   endtask

   // advance the reference model by one event of source code s
   task automatic model_event(int s, logic clr);
      m_uf = 1'b0;
      if (m_run && s == m_src) begin
         if (m_cnt == 0) begin
            m_cnt = m_rld; m_uf = 1'b1; m_pin = ~m_pin; m_irq = 1'b1;
         end else m_cnt = m_cnt - 1;
      end
      if (clr && !m_uf) m_irq = 1'b0;
   endtask

   task automatic wr_reg(logic sel, logic [7:0] d);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
      m_uf = 1'b0;
      if (sel == 1'b0) begin
         m_rld = d;
         if (!m_run) m_cnt = d;
      end else begin
         m_run = d[0]; m_src = d[2:1];
      end
   endtask

   // one cycle with a strobe from source s (0..2, -1 for none) and optional clear
   task automatic step(int s, logic clr);
      src_pwm_stb = (s == 0); src_presc_stb = (s == 1); src_wide_uf_stb = (s == 2);
      irq_clr = clr;
      @(negedge clk);
      src_pwm_stb = 0; src_presc_stb = 0; src_wide_uf_stb = 0; irq_clr = 0;
      model_event(s, clr);
   endtask

   task automatic pin_pulse(int high_cycles);
      ext_cnt_pin = 1'b1;
      repeat (high_cycles) @(negedge clk);
      ext_cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
      model_event(3, 1'b0);
      m_uf = 1'b0;
   endtask

   task automatic t_reset;
      chk_all("R1 reset");
      step(1, 1'b0);
      step(0, 1'b0);
      chk_all("R1 stopped ignores strobes");
   endtask

   task automatic t_preset;
      wr_reg(1'b0, 8'd5);
      chk_all("R9 preset while stopped");
   endtask

   task automatic t_divide(int n);
      int ufs = 0;
      wr_reg(1'b0, n[7:0]);
      wr_reg(1'b1, 8'h03);
      for (int i = 0; i <= n; i++) begin
         step(1, 1'b0);
         if (uf_pulse) ufs++;
         if (i == n) chk_all("R2 R4 R8 last event of period");
      end
      chk("R2 one underflow per n+1 events", ufs, 1);
      chk("R4 reloaded value", count_val, n);
      wr_reg(1'b1, 8'h02);
   endtask

   task automatic t_hold;
      wr_reg(1'b0, 8'd6);
      for (int i = 0; i < 3; i++) step(1, 1'b0);
      chk_all("R3 hold while stopped");
      wr_reg(1'b1, 8'h03);
      step(-1, 1'b0);
      step(-1, 1'b0);
      chk_all("R3 hold without event");
      step(1, 1'b0);
      chk_all("R3 decrement");
      wr_reg(1'b1, 8'h02);
   endtask

   task automatic t_select;
      wr_reg(1'b0, 8'd9);
      wr_reg(1'b1, 8'h05);
      step(0, 1'b0);
      step(1, 1'b0);
      chk_all("R5 unselected strobes ignored");
      step(2, 1'b0);
      chk_all("R5 wide underflow source");
      wr_reg(1'b1, 8'h01);
      step(1, 1'b0);
      step(0, 1'b0);
      chk_all("R5 pwm source");
      wr_reg(1'b1, 8'h00);
   endtask

   task automatic t_pin;
      wr_reg(1'b0, 8'd4);
      wr_reg(1'b1, 8'h07);
      pin_pulse(3);
      chk_all("R6 one pin edge");
      pin_pulse(20);
      chk_all("R6 long high counts once");
      step(1, 1'b0);
      chk_all("R6 R5 strobe ignored on pin source");
      pin_pulse(2);
      pin_pulse(2);
      chk_all("R6 R8 pin underflow");
      wr_reg(1'b1, 8'h06);
   endtask

   task automatic t_irq;
      step(-1, 1'b1);
      chk_all("R7 clear");
      wr_reg(1'b0, 8'd0);
      wr_reg(1'b1, 8'h03);
      step(1, 1'b0);
      chk_all("R7 set on underflow");
      step(-1, 1'b0);
      step(-1, 1'b0);
      chk_all("R7 sticky");
      step(-1, 1'b1);
      chk_all("R7 cleared");
      step(1, 1'b1);
      chk_all("R7 set wins over clear");
      wr_reg(1'b1, 8'h02);
   endtask

   task automatic t_run_write;
      wr_reg(1'b0, 8'd2);
      wr_reg(1'b1, 8'h03);
      step(1, 1'b0);
      wr_reg(1'b0, 8'd10);
      chk_all("R9 running write keeps count");
      step(1, 1'b0);
      step(1, 1'b0);
      chk_all("R9 new reload used at underflow");
      chk("R9 reloaded 10", count_val, 10);
      wr_reg(1'b1, 8'h02);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_preset();
      t_divide(0);
      t_divide(7);
      t_divide(255);
      t_hold();
      t_select();
      t_pin();
      t_irq();
      t_run_write();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule